// File: doc/BRIEF.md
# Per-Slot Key Usage Policy Enforcer

This block decides whether a key held in a protected slot may be used. It sits on the path between the key slot store and the cryptographic engines. For every slot it keeps a five-bit policy, a lock bit and a usage counter. A single request port carries a slot index, an operation code and, for provisioning, a policy word and a use cap. One cycle after each request the block returns either a grant pulse or a deny pulse with a reason code.

A grant raises a key-transfer enable together with the slot and the operation. The transfer engine uses it to move key bytes between the store and the engine registers. The processor has no port on this block that carries key material. The first provisioning of a slot writes its policy and cap and locks them until reset. Later requests are checked against the locked policy. When the counting flag is set, each granted use spends one count. A denied request leaves every slot untouched.

Top module: `key_policy_gate`

## Requirements
- R1: While reset is held and directly after it, every slot is unprovisioned and rsp_grant, rsp_deny, xfer_en and rsp_reason are all zero.
- R2: For each cycle with req_valid high, exactly one of rsp_grant or rsp_deny is high in the next cycle. No response is given without a request. rsp_reason is 0 on a grant.
- R3: The operation codes are 0 sign, 1 decapsulate, 2 export and 3 provision. A sign, decapsulate or export request on an unprovisioned slot is denied with reason 1. The first provision of a slot is granted, stores req_policy and req_cap, and locks the slot.
- R4: A slot index of NUM_SLOTS or more is denied with reason 6, whatever the operation.
- R5: Policy bit 0 (sign-only) lets only sign requests through. A decapsulate or export request on such a slot is denied with reason 2.
- R6: Policy bit 1 (decapsulate-only) lets only decapsulate requests through. A sign or export request on such a slot is denied with reason 2.
- R7: Policy bit 2 (no-export) denies export requests with reason 3.
- R8: On a locked slot with policy bit 3 (no-overwrite), a provision request is denied with reason 5. Without bit 3, it is granted as a key reload. The stored policy and count stay unchanged, and the new req_policy and req_cap are ignored.
- R9: With policy bit 4 (counter-limit), each granted sign, decapsulate or export request lowers the count by one. A use request at count zero is denied with reason 4. Without bit 4, uses are unlimited.
- R10: A denied request changes no policy, lock or count.
- R11: A grant raises xfer_en in the same cycle as rsp_grant. xfer_slot and xfer_op then equal the slot and operation of the request.
- R12: When several deny causes apply, the reason follows this priority: bad slot (6), then unprovisioned (1), then wrong operation (2), then no-export (3), then exhausted (4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_slot | input | SLOT_W | Slot index |
| req_op | input | 2 | Operation: 0 sign, 1 decap, 2 export, 3 provision |
| req_policy | input | 5 | Policy flags for a provision request |
| req_cap | input | CNT_W | Use cap for a provision request |
| rsp_grant | output | 1 | One-cycle grant pulse |
| rsp_deny | output | 1 | One-cycle deny pulse |
| rsp_reason | output | 3 | Deny reason, 0 when no deny |
| xfer_en | output | 1 | Key-transfer enable toward the engine path |
| xfer_slot | output | SLOT_W | Slot to transfer |
| xfer_op | output | 2 | Operation the transfer serves |

## Verification
The bench builds the block with six slots and a three-bit counter. A three-bit slot index then reaches the out-of-range indices 6 and 7. Caps of one or two exhaust a slot within a few requests, so the step from exhaustion to denial is exercised. Directed requests cover each policy flag, repeated provisioning and the ordering of deny reasons. A few hundred random back-to-back requests then mix the flag combinations. A behavioural model in the bench predicts every output on every clock.

// File: rtl/key_policy_gate.sv
module key_policy_gate #(
  parameter int NUM_SLOTS = 6,
  parameter int CNT_W     = 8,
  localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [SLOT_W-1:0] req_slot,
  input  logic [1:0]        req_op,
  input  logic [4:0]        req_policy,
  input  logic [CNT_W-1:0]  req_cap,
  output logic              rsp_grant,
  output logic              rsp_deny,
  output logic [2:0]        rsp_reason,
  output logic              xfer_en,
  output logic [SLOT_W-1:0] xfer_slot,
  output logic [1:0]        xfer_op
);
  localparam logic [1:0] OP_SIGN = 2'd0, OP_DECAP = 2'd1, OP_EXPORT = 2'd2, OP_PROV = 2'd3;
  localparam logic [2:0] RS_OK = 3'd0, RS_NOPROV = 3'd1, RS_WRONG = 3'd2, RS_NOEXP = 3'd3,
                         RS_EXH = 3'd4, RS_NOOVR = 3'd5, RS_BADSLOT = 3'd6;
  localparam logic [SLOT_W:0] SLOT_LIMIT = (SLOT_W+1)'(NUM_SLOTS);

  logic [4:0]       pol_q  [NUM_SLOTS];
  logic [CNT_W-1:0] cnt_q  [NUM_SLOTS];
  logic             lock_q [NUM_SLOTS];

  wire              in_rng = {1'b0, req_slot} < SLOT_LIMIT;
  wire [SLOT_W-1:0] idx    = in_rng ? req_slot : '0;
  wire [4:0]        cur_pol  = pol_q[idx];
  wire [CNT_W-1:0]  cur_cnt  = cnt_q[idx];
  wire              cur_lock = lock_q[idx];
  wire              is_prov  = (req_op == OP_PROV);

  logic [2:0] reason_d;
  always_comb begin
    reason_d = RS_OK;
    if (!in_rng)
      reason_d = RS_BADSLOT;
    else if (is_prov)
      reason_d = (cur_lock && cur_pol[3]) ? RS_NOOVR : RS_OK;
    else if (!cur_lock)
      reason_d = RS_NOPROV;
    else if ((req_op == OP_SIGN   && cur_pol[1]) ||
             (req_op == OP_DECAP  && cur_pol[0]) ||
             (req_op == OP_EXPORT && |cur_pol[1:0]))
      reason_d = RS_WRONG;
    else if (req_op == OP_EXPORT && cur_pol[2])
      reason_d = RS_NOEXP;
    else if (cur_pol[4] && cur_cnt == '0)
      reason_d = RS_EXH;
  end

  wire grant_d = req_valid && (reason_d == RS_OK);

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    wire hit = grant_d && (idx == SLOT_W'(i));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pol_q[i]  <= '0;
        cnt_q[i]  <= '0;
        lock_q[i] <= 1'b0;
      end else if (hit) begin
        if (is_prov && !lock_q[i]) begin
          pol_q[i]  <= req_policy;
          cnt_q[i]  <= req_cap;
          lock_q[i] <= 1'b1;
        end else if (!is_prov && pol_q[i][4]) begin
          cnt_q[i] <= cnt_q[i] - 1'b1;
        end
      end
    end

    // R3
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q[i] |=> lock_q[i]);
    // R8
    policy_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q[i] |=> $stable(pol_q[i]));
    // R9
    count_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q[i] |=> (cnt_q[i] <= $past(cnt_q[i])));
    // R10
    deny_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_deny |-> ($stable(cnt_q[i]) && $stable(pol_q[i]) && $stable(lock_q[i])));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_grant  <= 1'b0;
      rsp_deny   <= 1'b0;
      rsp_reason <= RS_OK;
      xfer_en    <= 1'b0;
      xfer_slot  <= '0;
      xfer_op    <= OP_SIGN;
    end else begin
      rsp_grant  <= grant_d;
      rsp_deny   <= req_valid && !grant_d;
      rsp_reason <= req_valid ? reason_d : RS_OK;
      xfer_en    <= grant_d;
      if (grant_d) begin
        xfer_slot <= req_slot;
        xfer_op   <= req_op;
      end
    end
  end

  // R2
  one_response_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (rsp_grant != rsp_deny));
  // R2
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_grant && !rsp_deny));
  // R4
  bad_slot_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !in_rng) |=> (rsp_deny && rsp_reason == RS_BADSLOT));
  // R9
  exhausted_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && in_rng && !is_prov && cur_lock && cur_pol[4] && cur_cnt == '0) |=> !rsp_grant);
  // R11
  xfer_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_en |-> (rsp_grant && xfer_slot == $past(req_slot) && xfer_op == $past(req_op)));
endmodule

// File: tb/key_policy_gate_tb.sv
module key_policy_gate_tb_top;
  localparam int NS = 6, CW = 3, SW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [SW-1:0] req_slot = '0;
  logic [1:0] req_op = '0;
  logic [4:0] req_policy = '0;
  logic [CW-1:0] req_cap = '0;
  logic rsp_grant, rsp_deny, xfer_en;
  logic [2:0] rsp_reason;
  logic [SW-1:0] xfer_slot;
  logic [1:0] xfer_op;

  key_policy_gate #(.NUM_SLOTS(NS), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_slot(req_slot),
    .req_op(req_op), .req_policy(req_policy), .req_cap(req_cap),
    .rsp_grant(rsp_grant), .rsp_deny(rsp_deny), .rsp_reason(rsp_reason),
    .xfer_en(xfer_en), .xfer_slot(xfer_slot), .xfer_op(xfer_op));

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  string cur_tag = "R1", e_tag = "R1";
  int m_pol [8];
  int m_cnt [8];
  bit m_lock [8];
  bit e_grant, e_deny, e_xfer;
  int e_reason, e_slot, e_op;

  function automatic int why(int s, int op);
    bit so, dso;
    if (s >= NS) return 6;
    so  = m_pol[s][0];
    dso = m_pol[s][1];
    if (op == 3) return (m_lock[s] && m_pol[s][3]) ? 5 : 0;
    if (!m_lock[s]) return 1;
    if (op == 0 && dso) return 2;
    if (op == 1 && so) return 2;
    if (op == 2 && (so || dso)) return 2;
    if (op == 2 && m_pol[s][2]) return 3;
    if (m_pol[s][4] && m_cnt[s] == 0) return 4;
    return 0;
  endfunction

  always @(posedge clk) begin
    e_tag = cur_tag;
    e_grant = 0; e_deny = 0; e_xfer = 0; e_reason = 0;
    if (!rst_n) begin
      for (int k = 0; k < 8; k++) begin m_pol[k] = 0; m_cnt[k] = 0; m_lock[k] = 0; end
    end else if (req_valid) begin
      int s, op, r;
      s = int'(req_slot); op = int'(req_op);
      r = why(s, op);
      if (r == 0) begin
        e_grant = 1; e_xfer = 1; e_slot = s; e_op = op;
        if (op == 3 && !m_lock[s]) begin
          m_pol[s] = int'(req_policy); m_cnt[s] = int'(req_cap); m_lock[s] = 1;
        end else if (op != 3 && m_pol[s][4]) begin
          m_cnt[s] = m_cnt[s] - 1;
        end
      end else begin
        e_deny = 1; e_reason = r;
      end
    end
  end

  always @(negedge clk) begin
    bit bad;
    checks++;
    bad = (rsp_grant !== e_grant) || (rsp_deny !== e_deny) || (int'(rsp_reason) != e_reason) ||
          (xfer_en !== e_xfer) ||
          (e_xfer && (int'(xfer_slot) != e_slot || int'(xfer_op) != e_op));
    if (bad) begin
      errors++;
      $display("FAIL %s: got g=%0b d=%0b rs=%0d x=%0b sl=%0d op=%0d exp g=%0b d=%0b rs=%0d x=%0b sl=%0d op=%0d",
               e_tag, rsp_grant, rsp_deny, rsp_reason, xfer_en, xfer_slot, xfer_op,
               e_grant, e_deny, e_reason, e_xfer, e_slot, e_op);
    end
  end

  task automatic rq(input int s, input int op, input int pol, input int cap, input string tag);
    cur_tag = tag;
    req_valid = 1'b1; req_slot = SW'(s); req_op = 2'(op);
    req_policy = 5'(pol); req_cap = CW'(cap);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  bit done = 0;
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R3 unprovisioned, first provision, plain slot
    rq(0, 0, 0, 0, "R3");
    rq(0, 3, 0, 0, "R3");
    rq(0, 0, 0, 0, "R11");
    rq(0, 2, 0, 0, "R11");
    for (int k = 0; k < 10; k++) rq(0, 1, 0, 0, "R9");
    // R5 sign-only
    rq(1, 3, 1, 0, "R5");
    rq(1, 0, 0, 0, "R5"); rq(1, 1, 0, 0, "R5"); rq(1, 2, 0, 0, "R5");
    // R6 decap-only
    rq(2, 3, 2, 0, "R6");
    rq(2, 1, 0, 0, "R6"); rq(2, 0, 0, 0, "R6"); rq(2, 2, 0, 0, "R6");
    // R7 no-export + R8 no-overwrite
    rq(3, 3, 12, 0, "R7");
    rq(3, 2, 0, 0, "R7"); rq(3, 0, 0, 0, "R7");
    rq(3, 3, 0, 5, "R8");
    // R8 reload keeps policy
    rq(0, 3, 17, 0, "R8");
    rq(0, 1, 0, 0, "R8"); rq(0, 2, 0, 0, "R8");
    // R9 counter limit
    rq(4, 3, 16, 2, "R9");
    rq(4, 0, 0, 0, "R9"); rq(4, 1, 0, 0, "R9"); rq(4, 2, 0, 0, "R9");
    // R10 deny leaves count intact
    rq(5, 3, 17, 1, "R10");
    rq(5, 1, 0, 0, "R10"); rq(5, 2, 0, 0, "R10");
    rq(5, 0, 0, 0, "R10"); rq(5, 0, 0, 0, "R10");
    // R12 priority
    rq(5, 1, 0, 0, "R12"); rq(3, 2, 0, 0, "R12"); rq(4, 1, 0, 0, "R12");
    // R4 bad slot
    rq(6, 0, 0, 0, "R4"); rq(7, 3, 0, 1, "R4");
    // R2 random back-to-back mix
    for (int k = 0; k < 300; k++) begin
      if ($urandom_range(0, 3) == 0) @(negedge clk);
      rq(int'($urandom_range(0, 7)), int'($urandom_range(0, 3)),
         int'($urandom_range(0, 31)), int'($urandom_range(0, 7)), "R2");
    end
    // R1 reset again
    cur_tag = "R1";
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rq(0, 0, 0, 0, "R1");
    rq(1, 3, 0, 0, "R3");
    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule